// File: doc/BRIEF.md
# Double-Buffered Co-Processor Bank Wrapper

This block wraps a compute kernel with eight private buffer banks: four input banks that the kernel reads from and four output banks that it writes to. A single external data port reaches every word of all eight banks, for reads and for writes. A memory controller uses this port to load input lines and to unload results. The kernel sees only narrow internal ports. On input banks it has a read-only port, and on output banks it has a write-only port. Each bank is a dual-port array, so both sides can work at once.

The banks form two halves. Half 0 takes input banks 0 and 1 and produces output banks 4 and 5. Half 1 takes input banks 2 and 3 and produces output banks 6 and 7. Within a half, two kernel lanes run in parallel, one per input/output bank pair. A pass runs on the half named by the bank-select status bit. When the pass ends, that bit flips, so the external side can fill and drain one half while the kernel works on the other.

The kernel here is a stub with two modes. It either copies each 32-bit complex word unchanged, or it halves both signed-magnitude 16-bit components. A pass covers either one line of a bank or the whole bank, which holds two lines processed in turn.

Top module: `cobuf_wrap`

## Requirements
- R1: After reset, busy, done and bankSel are all 0.
- R2: extAddr bits [IDXW+2:IDXW] select the bank (0-3 input, 4-7 output) and bits [IDXW-1:0] select the word. Any word of any bank can be written with extEn=1, extWe=1. A read with extEn=1, extWe=0 presents that word on extRdata from the cycle after the sampling edge.
- R3: A start sampled while busy is 0 begins a pass, and busy is 1 from the next cycle. A start sampled while busy is 1 is ignored, together with its long and scale values.
- R4: busy stays high for L+1 cycles, where L is LINE_WORDS with ctrlLong=0 and BANK_WORDS with ctrlLong=1. done rises as busy falls and is cleared by the next accepted start.
- R5: A pass uses the half given by bankSel at start. Input bank 2h+k word i goes to output bank 4+2h+k word i, for k in 0..1. bankSel inverts as busy falls.
- R6: A pass leaves the output banks of the other half unchanged.
- R7: With ctrlLong=0, only words 0..LINE_WORDS-1 are written. Later words of the output bank keep their contents.
- R8: With ctrlScale=0, each output word equals its input word.
- R9: With ctrlScale=1, each 16-bit component (bit 15 sign, bits 14:0 magnitude) has its magnitude shifted right by one with truncation. A zero result magnitude gets sign 0.
- R10: When the kernel and the external port write the same output word at the same edge, the kernel value is stored. An external read at that edge returns the word's previous contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ctrlStart | input | 1 | Start a pass (ignored while busy) |
| ctrlLong | input | 1 | 1: whole bank, 0: first line only |
| ctrlScale | input | 1 | 1: halve magnitudes, 0: copy |
| busy | output | 1 | Pass in progress |
| done | output | 1 | Last pass finished |
| bankSel | output | 1 | Half used by the next pass |
| extEn | input | 1 | External access enable |
| extWe | input | 1 | External write (else read) |
| extAddr | input | IDXW+3 | Bank and word address |
| extWdata | input | 32 | External write data |
| extRdata | output | 32 | External read data |

## Verification
Kernel write-back and external access can hit the same output word in the same cycle. The bench starts a full-bank pass and times external accesses by counting edges from the start: the kernel writes word k at the (k+2)th edge after the start is sampled. An external write on exactly that edge must lose to the kernel. An external write one edge later must win. An external read on the kernel's write edge must return the value from the previous pass.

// File: rtl/cobuf_pkg.sv
package cobuf_pkg;
  localparam int NUM_IN    = 4;
  localparam int NUM_OUT   = 4;
  localparam int NUM_BANKS = NUM_IN + NUM_OUT;
  localparam int LANES     = NUM_IN / 2;
  localparam int BSEL_W    = $clog2(NUM_BANKS);

  typedef struct packed {
    logic rdEn;
    logic wrEn;
    logic half;
    logic scale;
  } engStrobe_t;
endpackage

// File: rtl/cobuf_ctrl.sv
module cobuf_ctrl
  import cobuf_pkg::*;
#(
  parameter int BANK_WORDS = 16,
  parameter int LINE_WORDS = 8,
  localparam int IDXW = $clog2(BANK_WORDS)
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            ctrlStart,
  input  logic            ctrlLong,
  input  logic            ctrlScale,
  output logic            busy,
  output logic            done,
  output logic            bankSel,
  output engStrobe_t      strobe,
  output logic [IDXW-1:0] rdIdx,
  output logic [IDXW-1:0] wrIdx
);
  typedef enum logic [1:0] {IDLE, RUN, DRAIN} state_t;

  state_t          state;
  logic [IDXW-1:0] cnt, lastIdx, wrIdxQ;
  logic            halfQ, scaleQ, longQ, wrEnQ, doneQ, selQ;

  assign lastIdx = longQ ? IDXW'(BANK_WORDS - 1) : IDXW'(LINE_WORDS - 1);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= IDLE;
      cnt    <= '0;
      halfQ  <= 1'b0;
      scaleQ <= 1'b0;
      longQ  <= 1'b0;
      wrEnQ  <= 1'b0;
      wrIdxQ <= '0;
      doneQ  <= 1'b0;
      selQ   <= 1'b0;
    end else begin
      wrEnQ  <= (state == RUN);
      wrIdxQ <= cnt;
      case (state)
        IDLE: if (ctrlStart) begin
          state  <= RUN;
          cnt    <= '0;
          halfQ  <= selQ;
          scaleQ <= ctrlScale;
          longQ  <= ctrlLong;
          doneQ  <= 1'b0;
        end
        RUN: begin
          if (cnt == lastIdx) state <= DRAIN;
          else cnt <= cnt + 1'b1;
        end
        DRAIN: begin
          state <= IDLE;
          doneQ <= 1'b1;
          selQ  <= ~selQ;
        end
        default: state <= IDLE;
      endcase
    end
  end

  assign busy         = (state != IDLE);
  assign done         = doneQ;
  assign bankSel      = selQ;
  assign strobe.rdEn  = (state == RUN);
  assign strobe.wrEn  = wrEnQ;
  assign strobe.half  = halfQ;
  assign strobe.scale = scaleQ;
  assign rdIdx        = cnt;
  assign wrIdx        = wrIdxQ;
endmodule

// File: rtl/cobuf_datapath.sv
module cobuf_datapath
  import cobuf_pkg::*;
#(
  parameter int BANK_WORDS = 16,
  parameter int COMP_W     = 16,
  localparam int IDXW   = $clog2(BANK_WORDS),
  localparam int DATA_W = 2 * COMP_W,
  localparam int ADDR_W = IDXW + BSEL_W
) (
  input  logic              clk,
  input  engStrobe_t        strobe,
  input  logic [IDXW-1:0]   rdIdx,
  input  logic [IDXW-1:0]   wrIdx,
  input  logic              extEn,
  input  logic              extWe,
  input  logic [ADDR_W-1:0] extAddr,
  input  logic [DATA_W-1:0] extWdata,
  output logic [DATA_W-1:0] extRdata
);
  logic [BSEL_W-1:0] extBank, extSelQ;
  logic [IDXW-1:0]   extWord;
  logic [DATA_W-1:0] engRd   [NUM_IN];
  logic [DATA_W-1:0] extRd   [NUM_BANKS];
  logic [DATA_W-1:0] laneOut [LANES];

  assign extBank = extAddr[IDXW +: BSEL_W];
  assign extWord = extAddr[IDXW-1:0];

  function automatic logic [COMP_W-1:0] halveComp(input logic [COMP_W-1:0] v);
    logic [COMP_W-2:0] mag;
    mag = v[COMP_W-2:0] >> 1;
    return {v[COMP_W-1] && (mag != '0), mag};
  endfunction

  for (genvar b = 0; b < NUM_IN; b++) begin : g_in
    logic [DATA_W-1:0] mem [BANK_WORDS];
    logic [DATA_W-1:0] engQ, extQ;
    always_ff @(posedge clk) begin
      if (strobe.rdEn) engQ <= mem[rdIdx];
      if (extEn && extBank == BSEL_W'(b)) begin
        if (extWe) mem[extWord] <= extWdata;
        extQ <= mem[extWord];
      end
    end
    assign engRd[b] = engQ;
    assign extRd[b] = extQ;
  end

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    logic [DATA_W-1:0] laneIn;
    assign laneIn     = strobe.half ? engRd[LANES + k] : engRd[k];
    assign laneOut[k] = strobe.scale
                        ? {halveComp(laneIn[DATA_W-1 -: COMP_W]), halveComp(laneIn[COMP_W-1:0])}
                        : laneIn;
  end

  for (genvar o = 0; o < NUM_OUT; o++) begin : g_out
    logic [DATA_W-1:0] mem [BANK_WORDS];
    logic [DATA_W-1:0] extQ;
    logic              engWe;
    assign engWe = strobe.wrEn && (strobe.half == 1'(o / LANES));
    always_ff @(posedge clk) begin
      if (extEn && extBank == BSEL_W'(NUM_IN + o)) begin
        if (extWe) mem[extWord] <= extWdata;
        extQ <= mem[extWord];
      end
      if (engWe) mem[wrIdx] <= laneOut[o % LANES];
    end
    assign extRd[NUM_IN + o] = extQ;
  end

  always_ff @(posedge clk) begin
    if (extEn) extSelQ <= extBank;
  end

  assign extRdata = extRd[extSelQ];
endmodule

// File: rtl/cobuf_wrap.sv
module cobuf_wrap
  import cobuf_pkg::*;
#(
  parameter int BANK_WORDS = 16,
  parameter int LINE_WORDS = 8,
  parameter int COMP_W     = 16,
  localparam int IDXW   = $clog2(BANK_WORDS),
  localparam int DATA_W = 2 * COMP_W,
  localparam int ADDR_W = IDXW + BSEL_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ctrlStart,
  input  logic              ctrlLong,
  input  logic              ctrlScale,
  output logic              busy,
  output logic              done,
  output logic              bankSel,
  input  logic              extEn,
  input  logic              extWe,
  input  logic [ADDR_W-1:0] extAddr,
  input  logic [DATA_W-1:0] extWdata,
  output logic [DATA_W-1:0] extRdata
);
  engStrobe_t      strobe;
  logic [IDXW-1:0] rdIdx, wrIdx;

  cobuf_ctrl #(.BANK_WORDS(BANK_WORDS), .LINE_WORDS(LINE_WORDS)) ctrl_i (
    .clk(clk), .rstN(rstN), .ctrlStart(ctrlStart), .ctrlLong(ctrlLong),
    .ctrlScale(ctrlScale), .busy(busy), .done(done), .bankSel(bankSel),
    .strobe(strobe), .rdIdx(rdIdx), .wrIdx(wrIdx)
  );

  cobuf_datapath #(.BANK_WORDS(BANK_WORDS), .COMP_W(COMP_W)) dp_i (
    .clk(clk), .strobe(strobe), .rdIdx(rdIdx), .wrIdx(wrIdx),
    .extEn(extEn), .extWe(extWe), .extAddr(extAddr),
    .extWdata(extWdata), .extRdata(extRdata)
  );
endmodule

// File: rtl/cobuf_wrap_chk.sv
module cobuf_wrap_chk #(
  parameter int BANK_WORDS = 16,
  parameter int LINE_WORDS = 8
) (
  input logic clk,
  input logic rstN,
  input logic ctrlStart,
  input logic ctrlLong,
  input logic busy,
  input logic done,
  input logic bankSel
);
  int   busyCnt;
  logic longSeen;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busyCnt  <= 0;
      longSeen <= 1'b0;
    end else if (!busy && ctrlStart) begin
      busyCnt  <= 0;
      longSeen <= ctrlLong;
    end else if (busy) begin
      busyCnt <= busyCnt + 1;
    end
  end

  // R3
  start_accept_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && ctrlStart) |=> (busy && !done));

  // R4
  done_on_fall_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> done);

  // R4
  pass_len_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> (busyCnt == (longSeen ? BANK_WORDS + 1 : LINE_WORDS + 1)));

  // R5
  sel_flip_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> (bankSel != $past(bankSel)));

  // R5
  sel_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> $stable(bankSel));
endmodule

bind cobuf_wrap cobuf_wrap_chk #(.BANK_WORDS(BANK_WORDS), .LINE_WORDS(LINE_WORDS)) chk_i (
  .clk(clk), .rstN(rstN), .ctrlStart(ctrlStart), .ctrlLong(ctrlLong),
  .busy(busy), .done(done), .bankSel(bankSel)
);

// File: tb/cobuf_wrap_tb_top.sv
module cobuf_wrap_tb_top;
  localparam int BW = 16;
  localparam int LW = 8;
  localparam int AW = $clog2(BW) + 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic ctrlStart = 1'b0, ctrlLong = 1'b0, ctrlScale = 1'b0;
  logic busy, done, bankSel;
  logic extEn = 1'b0, extWe = 1'b0;
  logic [AW-1:0] extAddr = '0;
  logic [31:0] extWdata = '0;
  logic [31:0] extRdata;

  int nChecks = 0;
  int nFails = 0;

  // {input word, expected word with halving}
  localparam logic [63:0] VEC [8] = '{
    {32'h0000_0000, 32'h0000_0000},
    {32'h0002_0004, 32'h0001_0002},
    {32'h8002_8004, 32'h8001_8002},
    {32'h8001_0001, 32'h0000_0000},
    {32'h7FFF_FFFF, 32'h3FFF_BFFF},
    {32'h8100_0003, 32'h8080_0001},
    {32'h1234_9234, 32'h091A_891A},
    {32'hFFFE_0001, 32'hBFFF_0000}
  };

  cobuf_wrap #(.BANK_WORDS(BW), .LINE_WORDS(LW)) dut_i (
    .clk(clk), .rstN(rstN), .ctrlStart(ctrlStart), .ctrlLong(ctrlLong),
    .ctrlScale(ctrlScale), .busy(busy), .done(done), .bankSel(bankSel),
    .extEn(extEn), .extWe(extWe), .extAddr(extAddr),
    .extWdata(extWdata), .extRdata(extRdata)
  );

  always #4 clk = ~clk;

  function automatic logic [AW-1:0] mkAddr(input int b, input int w);
    return AW'(b * BW + w);
  endfunction

  function automatic logic [31:0] swapHalves(input logic [31:0] v);
    return {v[15:0], v[31:16]};
  endfunction

  function automatic logic [31:0] patB(input int i);
    return (32'h0101_0101 * i) ^ 32'h8000_1234;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic extWr(input int b, input int w, input logic [31:0] d);
    @(negedge clk);
    extEn = 1'b1; extWe = 1'b1; extAddr = mkAddr(b, w); extWdata = d;
    @(negedge clk);
    extEn = 1'b0; extWe = 1'b0;
  endtask

  task automatic extRd(input int b, input int w, output logic [31:0] d);
    @(negedge clk);
    extEn = 1'b1; extWe = 1'b0; extAddr = mkAddr(b, w);
    @(negedge clk);
    extEn = 1'b0;
    d = extRdata;
  endtask

  task automatic waitIdle(inout int cycles);
    while (1) begin
      @(negedge clk);
      if (!busy) break;
      cycles++;
    end
  endtask

  task automatic finishRun();
    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  endtask

  initial begin
    #(200000 * 8);
    nChecks++;
    nFails++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    logic [31:0] rd;
    int cycles;

    repeat (3) @(negedge clk);
    chk("R1 busy", {31'd0, busy}, 32'd0);
    chk("R1 done", {31'd0, done}, 32'd0);
    chk("R1 bankSel", {31'd0, bankSel}, 32'd0);
    rstN = 1'b1;

    // R2: every bank reachable for write and read
    for (int b = 0; b < 8; b++) extWr(b, 5, 32'hB000_0000 | (b << 8) | b);
    for (int b = 0; b < 8; b++) begin
      extRd(b, 5, rd);
      chk("R2 bank map", rd, 32'hB000_0000 | (b << 8) | b);
    end

    extWr(4, 9, 32'hDEAD_BEEF);   // R7 marker beyond first line
    extWr(6, 3, 32'hC0FF_EE00);   // R6 marker in other half

    for (int i = 0; i < 8; i++) begin
      extWr(0, i, VEC[i][63:32]);
      extWr(1, i, swapHalves(VEC[i][63:32]));
    end

    // Pass A: half 0, one line, halving; second start while busy ignored
    @(negedge clk);
    ctrlStart = 1'b1; ctrlLong = 1'b0; ctrlScale = 1'b1;
    @(negedge clk);
    chk("R3 busy after start", {31'd0, busy}, 32'd1);
    chk("R4 done cleared", {31'd0, done}, 32'd0);
    ctrlStart = 1'b1; ctrlLong = 1'b1; ctrlScale = 1'b0;
    @(negedge clk);
    ctrlStart = 1'b0;
    cycles = 2;
    waitIdle(cycles);
    chk("R3/R4 short pass length, ignored start", cycles, LW + 1);
    chk("R4 done set", {31'd0, done}, 32'd1);
    chk("R5 bankSel flipped", {31'd0, bankSel}, 32'd1);

    // Table walk: lane 0 and lane 1 of half 0
    for (int i = 0; i < 8; i++) begin
      extRd(4, i, rd);
      chk("R9 lane0 halving", rd, VEC[i][31:0]);
      extRd(5, i, rd);
      chk("R5 lane1 halving", rd, swapHalves(VEC[i][31:0]));
    end
    extRd(4, 9, rd);
    chk("R7 word past line kept", rd, 32'hDEAD_BEEF);
    extRd(6, 3, rd);
    chk("R6 other half kept", rd, 32'hC0FF_EE00);

    // Pass B: half 1, whole bank, copy
    for (int i = 0; i < BW; i++) begin
      extWr(2, i, patB(i));
      extWr(3, i, ~patB(i));
    end
    @(negedge clk);
    ctrlStart = 1'b1; ctrlLong = 1'b1; ctrlScale = 1'b0;
    @(negedge clk);
    ctrlStart = 1'b0;
    cycles = 1;
    waitIdle(cycles);
    chk("R4 long pass length", cycles, BW + 1);
    chk("R5 bankSel back", {31'd0, bankSel}, 32'd0);
    for (int i = 0; i < BW; i++) begin
      extRd(6, i, rd);
      chk("R8 copy lane0", rd, patB(i));
    end
    extRd(7, 12, rd);
    chk("R8 copy lane1", rd, ~patB(12));
    extRd(4, 1, rd);
    chk("R6 half 0 kept", rd, VEC[1][31:0]);

    // Pass C: collisions on output bank 4
    for (int i = 0; i < BW; i++) extWr(0, i, 32'h0100_0000 + i);
    @(negedge clk);                       // N0
    ctrlStart = 1'b1; ctrlLong = 1'b1; ctrlScale = 1'b0;
    @(negedge clk);                       // N1
    ctrlStart = 1'b0;
    chk("R4 done cleared on start", {31'd0, done}, 32'd0);
    @(negedge clk);                       // N2
    @(negedge clk);                       // N3
    @(negedge clk);                       // N4: same edge as kernel write of word 2
    extEn = 1'b1; extWe = 1'b1; extAddr = mkAddr(4, 2); extWdata = 32'hAAAA_5555;
    @(negedge clk);                       // N5
    extEn = 1'b0; extWe = 1'b0;
    @(negedge clk);                       // N6: read on kernel write edge of word 4
    extEn = 1'b1; extAddr = mkAddr(4, 4);
    @(negedge clk);                       // N7
    extEn = 1'b0;
    chk("R10 read-before-write", extRdata, VEC[4][31:0]);
    @(negedge clk);                       // N8
    @(negedge clk);                       // N9: one edge after kernel write of word 6
    extEn = 1'b1; extWe = 1'b1; extAddr = mkAddr(4, 6); extWdata = 32'h5555_AAAA;
    @(negedge clk);                       // N10
    extEn = 1'b0; extWe = 1'b0;
    cycles = 0;
    waitIdle(cycles);
    extRd(4, 2, rd);
    chk("R10 kernel wins same edge", rd, 32'h0100_0002);
    extRd(4, 6, rd);
    chk("R10 later external write kept", rd, 32'h5555_AAAA);
    extRd(4, 4, rd);
    chk("R8 copy after collision", rd, 32'h0100_0004);

    finishRun();
  end
endmodule